// File: doc/BRIEF.md
# Fly-by DMA Controller

This block is a four-channel direct memory access engine. It moves words between an I/O device and memory without ever holding the data. Software programs each channel through a small register write port with a start address, a transfer count, an enable bit and a direction bit. A device asks for service by raising its request line. The controller then asks the processor for the bus with a hold request. Once hold acknowledge comes back, the controller acknowledges the device and runs one bus cycle per word.

In each bus cycle the controller drives the memory address. It asserts the memory strobe and the I/O strobe that match the direction at the same time, so the word flows straight from the source to the destination. After each word the address rises by one and the count falls by one. When the count runs out, the controller releases the bus and pulses terminal count. Only one channel is active at a time. When several channels ask at once, the lowest-numbered eligible channel is served, and that choice holds until its burst ends or its request drops.

Top module: `flyby_dma`

## Requirements
- R1: After a synchronous active-low reset, all of the following are low: `hrq`, `dack`, `addr_oe`, `bus_addr`, every strobe and `tc`. Every channel starts disabled with address 0 and count 0.
- R2: An eligible request raises `hrq` on the next clock. The controller drives no address, strobe or `dack` until it has sampled `hlda` high. While it waits, it keeps `hrq` high only as long as the chosen channel's `dreq` stays high.
- R3: On the clock after `hlda` is sampled high, the controller asserts the `dack` bit of the active channel. `dack` is one-hot and stays high for every phase of each word of the burst.
- R4: With direction bit 0 (memory to device), `mem_rd` and `io_wr` are high together in the strobe phase, and `io_rd` and `mem_wr` stay low.
- R5: With direction bit 1 (device to memory), `io_rd` and `mem_wr` are high together in the strobe phase, and `mem_rd` and `io_wr` stay low.
- R6: Each word takes three cycles. The setup cycle drives the address with no strobe. The strobe cycle asserts the strobe pair. The release cycle drops the strobes and keeps the address. Only after the release cycle does the address rise by one and the count fall by one.
- R7: After the release cycle of the word that brings the count to zero, `hrq` and `dack` drop, and `tc` is high for exactly one cycle.
- R8: Among eligible channels, the lowest-numbered one wins. A lower-numbered request that arrives during a burst does not preempt the active channel.
- R9: If the active channel's `dreq` is low at the end of a word, the controller returns the bus (`hrq` low). A later request resumes at the updated address and count.
- R10: A channel that is disabled, or whose count is zero, ignores its `dreq`. `hrq` stays low.
- R11: While `hrq` is high, writes to the active channel's registers are ignored. Writes to other channels still take effect. Writes use the field select code 0 for address, 1 for count, and 2 for control, where bit 0 is enable and bit 1 is direction.
- R12: `hrq` stays high without a gap across back-to-back words of one burst. The next setup cycle follows the release cycle directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_sel | input | 2 | Field select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 16 | Write data |
| dreq | input | 4 | Device service requests, one per channel |
| dack | output | 4 | Device acknowledges, one per channel |
| hrq | output | 1 | Hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| addr_oe | output | 1 | Address bus drive enable |
| bus_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count pulse |

## Verification
The burst is exercised with single-channel runs in each direction, to tell apart the two strobe pairings. Grant latencies of zero and several cycles separate waiting for `hlda` from acting early. Requests that are withdrawn partway through a burst check that the bus is returned and the burst later resumes. Collisions between channels check that the lowest number wins and that the lock is held. A disabled channel, a zero count, and writes made in the middle of a burst check what must have no effect. A behavioural model of the handshake predicts every output on every clock.

// File: rtl/flyby_dma_pkg.sv
// Shared types and codes for the fly-by DMA controller.
// Assumes: consumers import the package before use.
package flyby_dma_pkg;

    // Bus-cycle phase of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HOLD  = 3'd1,
        PH_SETUP = 3'd2,
        PH_STRB  = 3'd3,
        PH_REL   = 3'd4
    } phase_t;

    // Register field select codes
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Control field bit positions
    localparam int CTRL_EN  = 0;
    localparam int CTRL_DIR = 1;

endpackage

// File: rtl/dma_chan_regs.sv
// One channel's programmable state: address pointer, word count, enable
// and direction. A step advances address and count after one word.
// Assumes: wr_en and step never assert together (the top gates writes
// to the active channel); CNT_W <= DATA_W.
module dma_chan_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              en,
    output logic              dir,
    output logic              ready
);

    // Program fields or advance pointer and count after a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
            en   <= 1'b0;
            dir  <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR: addr <= wr_data[ADDR_W-1:0];
                SEL_CNT:  cnt  <= wr_data[CNT_W-1:0];
                SEL_CTRL: begin
                    en  <= wr_data[CTRL_EN];
                    dir <= wr_data[CTRL_DIR];
                end
                default: ;
            endcase
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
            cnt  <= cnt - CNT_W'(1);
        end
    end

    // A channel can be served only when enabled and with words left.
    always_comb ready = en && (cnt != '0);

    // R6: a word is never completed on an exhausted count.
    p_step_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt != '0));

    // R6: one step moves the pointer up and the count down by one.
    p_step_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (addr == $past(addr) + ADDR_W'(1)) &&
                             (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority selector: the lowest-numbered eligible channel wins.
// Assumes: NUM_CH >= 2; purely combinational.
module dma_prio_pick #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] elig,
    output logic              any,
    output logic [CH_W-1:0]   win_idx,
    output logic [NUM_CH-1:0] grant
);

    // Scan from the top down so the lowest set bit is the last written.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = CH_W'(i);
        end
        any   = |elig;
        grant = any ? (NUM_CH'(1) << win_idx) : '0;
    end

    // R8: at most one channel granted, and only one that asked.
    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~elig) == '0));

    // R8: no eligible channel below the winner.
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((elig & ((NUM_CH'(1) << win_idx) - NUM_CH'(1))) == '0));

endmodule

// File: rtl/dma_cycle_seq.sv
// Bus-cycle sequencer: locks a channel, runs the hold handshake, then
// steps each word through setup, strobe and release phases, and ends
// the burst on exhaustion or a dropped request.
// Assumes: the processor keeps hlda high while hrq is high once granted.
module dma_cycle_seq
    import flyby_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [CH_W-1:0]   win_idx,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              act_last,
    input  logic              hlda,
    output phase_t            phase,
    output logic [CH_W-1:0]   act_idx,
    output logic              step,
    output logic              tc
);

    logic act_req;

    // Request line of the locked channel.
    always_comb act_req = dreq[act_idx];

    // Pointer update happens as the release phase ends.
    always_comb step = (phase == PH_REL);

    // Phase progression, channel lock and terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            act_idx <= '0;
            tc      <= 1'b0;
        end else begin
            tc <= 1'b0;
            case (phase)
                PH_IDLE: if (any_req) begin
                    act_idx <= win_idx;
                    phase   <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (!act_req)  phase <= PH_IDLE;
                    else if (hlda) phase <= PH_SETUP;
                end
                PH_SETUP: phase <= PH_STRB;
                PH_STRB:  phase <= PH_REL;
                PH_REL: begin
                    if (act_last) begin
                        phase <= PH_IDLE;
                        tc    <= 1'b1;
                    end else if (act_req) begin
                        phase <= PH_SETUP;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: the bus is entered only after the grant was seen.
    p_grant_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && $past(phase) == PH_HOLD) |-> $past(hlda));

    // R6: strobe phase always follows setup, release always follows strobe.
    p_phase_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STRB) |=> (phase == PH_REL));

    // R7: terminal count lasts one cycle and the bus is already released.
    p_tc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (phase == PH_IDLE) ##1 !tc);

    // R8: the locked channel never changes while a burst runs.
    p_lock_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(act_idx));

endmodule

// File: rtl/flyby_dma.sv
// Four-channel fly-by DMA controller top. Holds the channel registers,
// picks the requesting channel, and drives the handshake, the address
// and the strobe pairs. Data never passes through this block.
// Assumes: CNT_W <= ADDR_W; hlda stays high once granted until hrq drops.
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [NUM_CH-1:0] dreq,
    output logic [NUM_CH-1:0] dack,
    output logic              hrq,
    input  logic              hlda,
    output logic              addr_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              tc
);

    logic [ADDR_W-1:0] ch_addr [NUM_CH];
    logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
    logic [NUM_CH-1:0] ch_en, ch_dir, ch_ready, elig, grant;
    logic              any_req, step, on_bus, act_dir;
    logic [CH_W-1:0]   win_idx, act_idx;
    phase_t            phase;

    // Per-channel register sets; writes to the busy channel are dropped.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic wr_ok;
        always_comb wr_ok = cfg_we && (cfg_ch == CH_W'(g)) &&
                            !(hrq && act_idx == CH_W'(g));
        dma_chan_regs #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .DATA_W (ADDR_W)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ok),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .step    (step && act_idx == CH_W'(g)),
            .addr    (ch_addr[g]),
            .cnt     (ch_cnt[g]),
            .en      (ch_en[g]),
            .dir     (ch_dir[g]),
            .ready   (ch_ready[g])
        );
    end

    // Only programmed channels with words left may compete.
    always_comb elig = dreq & ch_ready;

    dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .any     (any_req),
        .win_idx (win_idx),
        .grant   (grant)
    );

    dma_cycle_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_req  (any_req),
        .win_idx  (win_idx),
        .dreq     (dreq),
        .act_last (ch_cnt[act_idx] == CNT_W'(1)),
        .hlda     (hlda),
        .phase    (phase),
        .act_idx  (act_idx),
        .step     (step),
        .tc       (tc)
    );

    // Bus-facing decode of the phase and the active channel.
    always_comb begin
        on_bus   = (phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_REL);
        act_dir  = ch_dir[act_idx];
        hrq      = (phase != PH_IDLE);
        addr_oe  = on_bus;
        dack     = on_bus ? (NUM_CH'(1) << act_idx) : '0;
        bus_addr = on_bus ? ch_addr[act_idx] : '0;
        mem_rd   = (phase == PH_STRB) && !act_dir;
        io_wr    = (phase == PH_STRB) && !act_dir;
        io_rd    = (phase == PH_STRB) && act_dir;
        mem_wr   = (phase == PH_STRB) && act_dir;
    end

    // R2: no bus drive without the processor's grant.
    p_bus_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> hlda);

    // R3: the device acknowledge is one-hot.
    p_dack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R4/R5: never read and write the same side in one cycle.
    p_no_same_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));

    // R6: the address does not move between strobe and release.
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REL) |-> $stable(bus_addr));

    // R12: hold request stays up from one word into the next.
    p_hold_continuous_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP && $past(phase) == PH_REL) |-> $past(hrq));

endmodule

// File: tb/flyby_dma_tb.sv
// Bench: behavioural reference of the handshake compared every cycle,
// plus directed checks for priority, locking and ignored stimulus.
module flyby_dma_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hrq, hlda, addr_oe, mem_rd, mem_wr, io_rd, io_wr, tc;
    logic [15:0] bus_addr;

    int total = 0;
    int bad = 0;
    int gnt_lat = 0;
    int gnt_cnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    flyby_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
        .hrq(hrq), .hlda(hlda), .addr_oe(addr_oe), .bus_addr(bus_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Processor model: grants after gnt_lat cycles and holds while hrq is high.
    initial hlda = 1'b0;
    always @(posedge clk) begin
        #2;
        if (!hrq) begin
            hlda = 1'b0;
            gnt_cnt = 0;
        end else if (gnt_cnt >= gnt_lat) begin
            hlda = 1'b1;
        end else begin
            gnt_cnt++;
        end
    end

    // Reference model: phase 0 idle, 1 waiting, 2 setup, 3 strobe, 4 release.
    logic [15:0] m_addr [NCH];
    int          m_cnt  [NCH];
    bit          m_en   [NCH];
    bit          m_dir  [NCH];
    int          m_ph = 0;
    int          m_ch = 0;
    bit          m_tc = 0;

    always @(posedge clk) begin
        int win;
        bit blocked;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_addr[i] = '0; m_cnt[i] = 0; m_en[i] = 0; m_dir[i] = 0;
            end
            m_ph = 0; m_ch = 0; m_tc = 0;
        end else begin
            win = -1;
            for (int i = NCH - 1; i >= 0; i--)
                if (dreq[i] && m_en[i] && m_cnt[i] != 0) win = i;
            blocked = (m_ph != 0) && (int'(cfg_ch) == m_ch);
            m_tc = 0;
            case (m_ph)
                0: if (win >= 0) begin m_ch = win; m_ph = 1; end
                1: if (!dreq[m_ch]) m_ph = 0; else if (hlda) m_ph = 2;
                2: m_ph = 3;
                3: m_ph = 4;
                default: begin
                    m_addr[m_ch] = m_addr[m_ch] + 16'd1;
                    m_cnt[m_ch] = m_cnt[m_ch] - 1;
                    if (m_cnt[m_ch] == 0) begin m_ph = 0; m_tc = 1; end
                    else if (dreq[m_ch]) m_ph = 2;
                    else m_ph = 0;
                end
            endcase
            if (cfg_we && !blocked) begin
                case (cfg_sel)
                    2'd0: m_addr[cfg_ch] = cfg_wdata;
                    2'd1: m_cnt[cfg_ch] = int'(cfg_wdata[11:0]);
                    2'd2: begin m_en[cfg_ch] = cfg_wdata[0]; m_dir[cfg_ch] = cfg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    // Compare every output against the model in mid-cycle.
    always @(negedge clk) begin
        bit ob;
        if (rst_n) begin
            ob = (m_ph >= 2);
            check("R2", "hrq", int'(hrq), int'(m_ph != 0));
            check("R3", "dack", int'(dack), ob ? (1 << m_ch) : 0);
            check("R6", "addr_oe", int'(addr_oe), int'(ob));
            check("R6", "bus_addr", int'(bus_addr), ob ? int'(m_addr[m_ch]) : 0);
            check("R4", "mem_rd", int'(mem_rd), int'(m_ph == 3 && !m_dir[m_ch]));
            check("R4", "io_wr", int'(io_wr), int'(m_ph == 3 && !m_dir[m_ch]));
            check("R5", "io_rd", int'(io_rd), int'(m_ph == 3 && m_dir[m_ch]));
            check("R5", "mem_wr", int'(mem_wr), int'(m_ph == 3 && m_dir[m_ch]));
            check("R7", "tc", int'(tc), int'(m_tc));
        end
    end

    task automatic wr(input int ch, input int sel, input int val);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(val);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input int a, input int n, input int ctrl);
        wr(ch, 0, a); wr(ch, 1, n); wr(ch, 2, ctrl);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic wait_tc();
        for (int i = 0; i < 200 && !tc; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen;
        wait_cyc(3);
        @(negedge clk);
        // R1: reset state before release
        check("R1", "reset hrq/dack/strobes/tc",
              int'({hrq, dack, addr_oe, mem_rd, mem_wr, io_rd, io_wr, tc}), 0);
        check("R1", "reset bus_addr", int'(bus_addr), 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R4 R6 R7 R12: channel 2 memory to device, 3 words, slow grant
        gnt_lat = 3;
        prog(2, 'h100, 3, 1);
        dreq[2] = 1'b1;
        wait_tc();
        check("R7", "tc seen for ch2 burst", int'(tc), 1);
        @(posedge clk); #2; dreq[2] = 1'b0;
        wait_cyc(3);

        // R5: channel 1 device to memory, immediate grant
        gnt_lat = 0;
        prog(1, 'h2000, 2, 3);
        dreq[1] = 1'b1;
        seen = 0;
        for (int i = 0; i < 40 && !tc; i++) begin
            @(negedge clk);
            if (io_rd && mem_wr) seen++;
        end
        check("R5", "io_rd/mem_wr pulses", seen, 2);
        @(posedge clk); #2; dreq[1] = 1'b0;
        wait_cyc(3);

        // R10: disabled channel and zero count are ignored
        prog(3, 'h40, 4, 0);
        prog(0, 'h50, 0, 1);
        dreq = 4'b1001;
        wait_cyc(8);
        @(negedge clk);
        check("R10", "hrq with disabled/zero-count requests", int'(hrq), 0);
        dreq = 4'b0000;

        // R8: simultaneous requests, lowest wins; lock against a newcomer
        prog(0, 'h300, 2, 1);
        prog(3, 'h400, 4, 1);
        dreq = 4'b1001;
        for (int i = 0; i < 20 && dack == 0; i++) @(negedge clk);
        check("R8", "lowest channel wins", int'(dack), 1);
        wait_tc();
        @(posedge clk); #2; dreq[0] = 1'b0;
        for (int i = 0; i < 20 && dack == 0; i++) @(negedge clk);
        check("R8", "ch3 served after ch0", int'(dack), 8);
        @(posedge clk); #2;
        prog(0, 'h500, 2, 1);
        dreq[0] = 1'b1;
        @(negedge clk);
        check("R8", "no preemption by ch0", int'(dack), 8);
        // R11: writes to the busy channel are dropped
        wr(3, 0, 'h7777);
        wait_tc();
        @(posedge clk); #2; dreq = 4'b0000;
        wait_cyc(4);

        // R9: request withdrawn mid-burst, resumed later
        gnt_lat = 1;
        prog(1, 'h800, 5, 1);
        dreq[1] = 1'b1;
        for (int i = 0; i < 20 && !mem_rd; i++) @(negedge clk);
        @(posedge clk); #2; dreq[1] = 1'b0;
        wait_cyc(3);
        @(negedge clk);
        check("R9", "bus returned after drop", int'(hrq), 0);
        dreq[1] = 1'b1;
        for (int i = 0; i < 20 && !addr_oe; i++) @(negedge clk);
        check("R9", "resume address", int'(bus_addr), 'h801);
        wait_tc();
        @(posedge clk); #2; dreq = 4'b0000;
        wait_cyc(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule